// File: doc/BRIEF.md
# Counting-Ramp Conversion Controller

This block sequences an analog-to-digital conversion that searches upward from zero. A start request clears a binary counter and marks the block busy. The counter then steps up by one on every clock, and its value is driven straight onto the input bus of an external DAC. An external comparator reports when the DAC voltage rises above the held input voltage. With the default 8-bit width the codes 0 to 255 cover a 0 to 5 V span.

The comparator bit is asynchronous to the block's clock, so it passes through a chain of synchronizing flops before it is used. Every counter value is carried through a matching chain of tag registers. When a comparator sample reaches the end of its chain, the block knows which DAC code was on the bus when that sample was taken. That code becomes the result. It is the lowest code whose voltage lies above the input.

If the counter reaches full scale and the comparator has still not reported high, the conversion ends with the full-scale code. The end of a conversion is marked by a single-cycle done pulse. The result stays unchanged until the next conversion ends. The conversion time depends on the input: it is the result code plus a fixed overhead of SYNC_STAGES + 1 cycles.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, busy and done are 0, and dac_code and result are 0.
- R2: A start that is high at a clock edge while the block is idle sets busy and drives dac_code to 0 after that edge.
- R3: While busy, dac_code rises by exactly one per clock and holds at the all-ones code (255 for WIDTH=8).
- R4: The result is the DAC code that was on the bus when the synchronized comparator first read 1. This is the lowest code above the input.
- R5: If the comparator never reads 1, the conversion ends with result equal to the all-ones code.
- R6: done is high for exactly one cycle and falls together with busy. For result c it rises c + SYNC_STAGES + 1 clock edges after the start edge (c + 3 with the default SYNC_STAGES=2).
- R7: A start request while busy is ignored: the count, the result and the completion time are unchanged.
- R8: result keeps its value during a following conversion until that conversion's done pulse.
- R9: If the comparator reads 1 at code 0, the result is 0.
- R10: While idle, comparator activity has no effect: no done pulse, and busy, dac_code and result stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a conversion |
| cmp_in | input | 1 | Comparator output, high when the DAC voltage is above the input |
| dac_code | output | WIDTH | Code driven to the external DAC |
| result | output | WIDTH | Code of the last completed conversion |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default values, WIDTH=8 and SYNC_STAGES=2. With these values a full-scale conversion takes 258 cycles, so both the saturation path and a trip at code 255 can be reached in one run. Both end with the same code and at the same time. A two-stage synchronizer gives a fixed overhead of three cycles, so every completion time can be predicted exactly from the threshold that the behavioural comparator is given.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             done
);
  localparam logic [WIDTH-1:0] FULL = '1;
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cmp_s;
  logic [SYNC_STAGES-1:0] tag_v;
  logic [WIDTH-1:0]       tag_c [SYNC_STAGES];
  logic [WIDTH-1:0]       cnt;

  wire launch = start & ~busy;
  wire finish = busy & tag_v[LAST] & (cmp_s[LAST] | (tag_c[LAST] == FULL));

  // comparator synchronizer with a parallel chain of code tags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_s <= '0;
      tag_v <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) tag_c[i] <= '0;
    end else begin
      cmp_s    <= {cmp_s[SYNC_STAGES-2:0], cmp_in};
      tag_v    <= launch ? '0 : {tag_v[SYNC_STAGES-2:0], busy};
      tag_c[0] <= cnt;
      for (int i = 1; i < SYNC_STAGES; i++) tag_c[i] <= tag_c[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (launch) begin
        cnt  <= '0;
        busy <= 1'b1;
      end else if (finish) begin
        busy   <= 1'b0;
        result <= tag_c[LAST];
      end else if (busy && cnt != FULL) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dac_code = cnt;

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt == '0));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cnt) != FULL) |-> (cnt == $past(cnt) + 1'b1));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(cnt) && !done));
endmodule

// File: tb/ramp_adc_ctrl_bench.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_bench;
  localparam int W = 8;
  localparam int MAXC = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic force_cmp = 1'b0;
  int   thresh = 1000;
  logic cmp_in;
  logic [W-1:0] dac_code, result;
  logic busy, done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // behavioural DAC plus comparator: high when the DAC code lies above the input
  assign cmp_in = force_cmp | (int'(dac_code) > thresh);

  ramp_adc_ctrl u_ramp_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(dac_code == '0, "R1 dac_code", dac_code, 0);
    chk(result == '0, "R1 result", result, 0);
  endtask

  task automatic convert(input int th, input int exp_code, input bit poke, input string req);
    int prev = int'(result);
    int lim = exp_code + 3;
    bit seen = 0;
    thresh = th;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(dac_code == '0, "R2 dac cleared", dac_code, 0);
    for (int k = 1; k <= lim + 2; k++) begin
      @(negedge clk);
      start = (poke && (k == 10 || k == 11)) ? 1'b1 : 1'b0;
      if (done) begin
        chk(k == lim, {req, " R6 done timing"}, k, lim);
        chk(int'(result) == exp_code, {req, " R4 result"}, result, exp_code);
        chk(busy == 1'b0, "R6 busy falls with done", busy, 0);
        seen = 1;
        break;
      end
      chk(int'(dac_code) == ((k < MAXC) ? k : MAXC), "R3 ramp", dac_code, (k < MAXC) ? k : MAXC);
      chk(int'(result) == prev, "R8 result held", result, prev);
    end
    start = 1'b0;
    chk(seen, {req, " R6 done seen"}, seen, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 single-cycle done", done, 0);
    chk(int'(result) == exp_code, "R8 result after done", result, exp_code);
  endtask

  task automatic test_idle_cmp();
    logic [W-1:0] r0 = result;
    logic [W-1:0] d0 = dac_code;
    thresh = 1000;
    force_cmp = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R10 idle no done", {done, busy}, 0);
    end
    chk(result == r0, "R10 result unchanged", result, r0);
    chk(dac_code == d0, "R10 dac unchanged", dac_code, d0);
    force_cmp = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    convert(100, 101, 0, "mid-scale");
    convert(5, 6, 0, "low");
    convert(-1, 0, 0, "R9 zero");
    convert(40, 41, 1, "R7 start while busy");
    convert(254, 255, 0, "trip at top");
    convert(300, MAXC, 0, "R5 full scale");
    test_idle_cmp();
    convert(17, 18, 0, "after idle");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule